// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block decides which pending interrupt the processor core services next and hands the core a service descriptor: a kind code and a 16-bit vector. Four sources compete. An active-low halt request asks the core to enter console mode. Two fixed-vector request lines carry hardwired vectors. A chain of peripheral devices also raises requests and supplies its own vectors.

For the peripheral chain, the block runs an acknowledge cycle. It raises a read strobe and a grant. The grant ripples from device to device in chain order. The first device that is requesting keeps the grant, so every device behind it is blocked. That device then puts its vector on the shared data lines and pulses a reply. If no reply arrives within a fixed number of cycles, the cycle is abandoned and nothing is offered. Fixed-vector lines and the halt line never start a bus cycle.

Request lines pass through a two-stage synchronizer. A new decision is taken only when the core signals an instruction boundary. Nesting is left to the core. Once it has entered a handler it may raise the interrupt enable again, and a higher-priority source is then accepted at the next boundary. The chain elements are built into the block, one for each device slot, with slot 0 nearest the controller.

Top module: `vint_ack_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `svc_valid`, `rd_strobe`, `iak_out` and `ack_timeout` are low.
- R2: A decision is taken only in a cycle where `instr_bnd` is high while no acknowledge cycle is running and no descriptor is pending. Without `instr_bnd`, held requests cause no offer and no strobe.
- R3: Priority from highest to lowest is: halt request, fixed line `fix_hi_req`, fixed line `fix_lo_req`, device chain.
- R4: `halt_n` is active low. It is accepted even when `int_en` is low, and it is offered with kind 3 and vector 0.
- R5: With `int_en` low, the fixed lines and the device chain are ignored.
- R6: The fixed lines are offered with kind 1 in the cycle after the deciding edge, without raising `rd_strobe`. `fix_hi_req` carries vector 0o100 (64) and `fix_lo_req` carries vector 0o270 (184).
- R7: An accepted chain request raises `rd_strobe` and `iak_out` together in the cycle after the deciding edge. The lowest-indexed requesting slot takes the grant, and its `dev_vec` slice (slot i at bits i*16+15:i*16) is offered with kind 2.
- R8: In a chain acknowledge, the vector is offered two cycles after `rd_strobe` rises, and `rd_strobe` is low while it is offered.
- R9: If no reply arrives within TMO (default 64) cycles of strobe, `rd_strobe` and `iak_out` drop. `ack_timeout` is high for exactly one cycle, and no descriptor is offered.
- R10: Back-pressure: while `svc_valid` is high and `svc_ready` is low, `svc_kind` and `svc_vector` hold and no new request is taken. A handshake returns the block to idle, and the next decision needs a later boundary cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_bnd | input | 1 | Core is at an instruction boundary |
| int_en | input | 1 | Maskable interrupts allowed |
| halt_n | input | 1 | Halt/console request, active low |
| fix_hi_req | input | 1 | Fixed-vector request, vector 0o100 |
| fix_lo_req | input | 1 | Fixed-vector request, vector 0o270 |
| dev_req | input | NDEV | Request from each chain slot |
| dev_vec | input | NDEV*VW | Vector of each chain slot |
| svc_valid | output | 1 | Service descriptor valid |
| svc_ready | input | 1 | Core accepts the descriptor |
| svc_kind | output | 2 | 1 fixed, 2 chain vector, 3 halt |
| svc_vector | output | VW | Vector to service |
| rd_strobe | output | 1 | Vector read strobe of the acknowledge cycle |
| iak_out | output | 1 | Grant entering the chain |
| ack_timeout | output | 1 | One-cycle pulse on an abandoned acknowledge |

## Verification
The hardest case to reach is the unanswered acknowledge. At the request edge some device has to be requesting, or the controller never starts the cycle. Yet no device may still be requesting when the grant reaches it. The stimulus raises one slot's request, pulses the boundary, and withdraws the request in the half-cycle after the strobe rises, before the slot samples its grant. The grant then runs off the end of the chain, and the bench counts the cycles up to the timeout pulse.

// File: rtl/vint_pkg.sv
package vint_pkg;
  typedef enum logic [1:0] {
    SVC_NONE  = 2'd0,
    SVC_FIXED = 2'd1,
    SVC_VEC   = 2'd2,
    SVC_HALT  = 2'd3
  } svc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACK   = 2'd1,
    ST_OFFER = 2'd2
  } ctl_state_e;

  localparam logic [15:0] VEC_FIX_HI = 16'o100;
  localparam logic [15:0] VEC_FIX_LO = 16'o270;
  localparam logic [15:0] VEC_HALT   = 16'h0000;
endpackage

// File: rtl/vint_sync.sv
module vint_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vint_chain_elem.sv
module vint_chain_elem #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iak_in,
  input  logic          req,
  input  logic [VW-1:0] vec,
  output logic          iak_out,
  output logic          claim,
  output logic [VW-1:0] vec_drv
);
  logic claim_q;

  // A requesting slot keeps the grant; others pass it on.
  assign iak_out = iak_in & ~req;

  // One-cycle reply pulse per grant.
  always_ff @(posedge clk) begin
    if (!rst_n) claim_q <= 1'b0;
    else        claim_q <= iak_in & req & ~claim_q;
  end

  assign claim   = claim_q;
  assign vec_drv = claim_q ? vec : '0;
endmodule

// File: rtl/vint_ack_fsm.sv
module vint_ack_fsm
  import vint_pkg::*;
#(
  parameter int VW  = 16,
  parameter int TMO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd,
  input  logic          int_en,
  input  logic          halt_s,
  input  logic          fhi_s,
  input  logic          flo_s,
  input  logic          virq_s,
  input  logic          rply,
  input  logic [VW-1:0] ad,
  input  logic          svc_ready,
  output logic          rd_strobe,
  output logic          iak,
  output logic          svc_valid,
  output logic [1:0]    svc_kind,
  output logic [VW-1:0] svc_vector,
  output logic          ack_timeout
);
  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

  ctl_state_e    state;
  logic [CW-1:0] cnt;
  svc_kind_e     kind_q;
  logic [VW-1:0] vec_q;
  logic          tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      kind_q <= SVC_NONE;
      vec_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (bnd) begin
            if (halt_s) begin
              state  <= ST_OFFER;
              kind_q <= SVC_HALT;
              vec_q  <= VW'(VEC_HALT);
            end else if (int_en && fhi_s) begin
              state  <= ST_OFFER;
              kind_q <= SVC_FIXED;
              vec_q  <= VW'(VEC_FIX_HI);
            end else if (int_en && flo_s) begin
              state  <= ST_OFFER;
              kind_q <= SVC_FIXED;
              vec_q  <= VW'(VEC_FIX_LO);
            end else if (int_en && virq_s) begin
              state <= ST_ACK;
              cnt   <= '0;
            end
          end
        end
        ST_ACK: begin
          if (rply) begin
            state  <= ST_OFFER;
            kind_q <= SVC_VEC;
            vec_q  <= ad;
          end else if (cnt == CNT_LAST) begin
            state <= ST_IDLE;
            tmo_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OFFER: begin
          if (svc_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_strobe   = (state == ST_ACK);
  assign iak         = (state == ST_ACK);
  assign svc_valid   = (state == ST_OFFER);
  assign svc_kind    = kind_q;
  assign svc_vector  = vec_q;
  assign ack_timeout = tmo_q;

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && !svc_ready |=> svc_valid && $stable(svc_vector) && $stable(svc_kind)); // R10
  AST_ACK_AT_BND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strobe) |-> $past(bnd)); // R2
  AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ack_timeout |-> !rd_strobe && !svc_valid); // R9
  AST_FIXED_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_valid) && svc_kind == SVC_FIXED |-> $past(int_en) && !$past(rd_strobe)); // R5
endmodule

// File: rtl/vint_ack_ctrl.sv
module vint_ack_ctrl
  import vint_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int VW   = 16,
  parameter int TMO  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_bnd,
  input  logic               int_en,
  input  logic               halt_n,
  input  logic               fix_hi_req,
  input  logic               fix_lo_req,
  input  logic [NDEV-1:0]    dev_req,
  input  logic [NDEV*VW-1:0] dev_vec,
  output logic               svc_valid,
  input  logic               svc_ready,
  output logic [1:0]         svc_kind,
  output logic [VW-1:0]      svc_vector,
  output logic               rd_strobe,
  output logic               iak_out,
  output logic               ack_timeout
);
  localparam int NSRC = 4;

  logic [NSRC-1:0] raw, synced;
  logic            halt_s, fhi_s, flo_s, virq_s;
  logic            iak;
  logic [NDEV:0]   gchain;
  logic [NDEV-1:0] claim;
  logic [VW-1:0]   vdrv [NDEV];
  logic [VW-1:0]   ad;
  logic            rply;

  assign raw = {halt_n, fix_hi_req, fix_lo_req, |dev_req};

  vint_sync #(.W(NSRC), .STAGES(2), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign halt_s = ~synced[3];
  assign fhi_s  = synced[2];
  assign flo_s  = synced[1];
  assign virq_s = synced[0];

  assign gchain[0] = iak;

  generate
    for (genvar i = 0; i < NDEV; i++) begin : g_slot
      vint_chain_elem #(.VW(VW)) u_elem (
        .clk(clk), .rst_n(rst_n),
        .iak_in(gchain[i]), .req(dev_req[i]),
        .vec(dev_vec[i*VW +: VW]),
        .iak_out(gchain[i+1]), .claim(claim[i]), .vec_drv(vdrv[i])
      );
    end
  endgenerate

  always_comb begin
    ad = '0;
    for (int i = 0; i < NDEV; i++) ad = ad | vdrv[i];
  end

  assign rply = |claim;

  vint_ack_fsm #(.VW(VW), .TMO(TMO)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bnd(instr_bnd), .int_en(int_en),
    .halt_s(halt_s), .fhi_s(fhi_s), .flo_s(flo_s), .virq_s(virq_s),
    .rply(rply), .ad(ad), .svc_ready(svc_ready),
    .rd_strobe(rd_strobe), .iak(iak), .svc_valid(svc_valid),
    .svc_kind(svc_kind), .svc_vector(svc_vector), .ack_timeout(ack_timeout)
  );

  assign iak_out = iak;

  AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim)); // R7
  AST_RPLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rply |-> rd_strobe); // R7
endmodule

// File: tb/vint_ack_ctrl_tb.sv
module vint_ack_ctrl_tb_top;
  localparam int NDEV = 4;
  localparam int VW   = 16;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_bnd = 1'b0, int_en = 1'b0, halt_n = 1'b1;
  logic fix_hi_req = 1'b0, fix_lo_req = 1'b0;
  logic [NDEV-1:0] dev_req = '0;
  logic [NDEV*VW-1:0] dev_vec;
  logic svc_valid, svc_ready = 1'b0;
  logic [1:0] svc_kind;
  logic [VW-1:0] svc_vector;
  logic rd_strobe, iak_out, ack_timeout;

  int n_chk = 0, n_fail = 0, cyc = 0;

  assign dev_vec = {16'o314, 16'o310, 16'o304, 16'o300};

  always #10 clk = ~clk;

  vint_ack_ctrl #(.NDEV(NDEV), .VW(VW), .TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_bnd(instr_bnd), .int_en(int_en),
    .halt_n(halt_n), .fix_hi_req(fix_hi_req), .fix_lo_req(fix_lo_req),
    .dev_req(dev_req), .dev_vec(dev_vec), .svc_valid(svc_valid),
    .svc_ready(svc_ready), .svc_kind(svc_kind), .svc_vector(svc_vector),
    .rd_strobe(rd_strobe), .iak_out(iak_out), .ack_timeout(ack_timeout)
  );

  // fields: halt_n, hi, lo, dev[3:0], en | valid, kind[1:0], vec[15:0]
  localparam int NV = 9;
  localparam logic [26:0] TBL [NV] = '{
    {1'b0, 1'b1, 1'b1, 4'b1111, 1'b0, 1'b1, 2'd3, 16'd0},    // R3 R4 halt unmasked
    {1'b1, 1'b1, 1'b1, 4'b1111, 1'b1, 1'b1, 2'd1, 16'o100},  // R3 R6
    {1'b1, 1'b0, 1'b1, 4'b1111, 1'b1, 1'b1, 2'd1, 16'o270},  // R3 R6
    {1'b1, 1'b0, 1'b0, 4'b1100, 1'b1, 1'b1, 2'd2, 16'o310},  // R7
    {1'b1, 1'b0, 1'b0, 4'b1111, 1'b1, 1'b1, 2'd2, 16'o300},  // R7
    {1'b1, 1'b0, 1'b0, 4'b1000, 1'b1, 1'b1, 2'd2, 16'o314},  // R7 last slot
    {1'b1, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 2'd0, 16'd0},    // R5
    {1'b1, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, 2'd0, 16'd0},    // R5
    {1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd0, 16'd0}     // R2 nothing pending
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    halt_n = 1'b1; fix_hi_req = 1'b0; fix_lo_req = 1'b0; dev_req = '0;
  endtask

  task automatic bnd_pulse();
    instr_bnd = 1'b1;
    @(negedge clk);
    instr_bnd = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", svc_valid, 0);
    chk("R1 strobe in reset", rd_strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", svc_valid, 0);
    chk("R1 iak", iak_out, 0);
    chk("R1 timeout", ack_timeout, 0);

    for (int k = 0; k < NV; k++) begin
      halt_n = TBL[k][26]; fix_hi_req = TBL[k][25]; fix_lo_req = TBL[k][24];
      dev_req = TBL[k][23:20]; int_en = TBL[k][19];
      repeat (3) @(negedge clk);
      bnd_pulse();
      repeat (2) @(negedge clk);
      chk($sformatf("R3 row%0d valid", k), svc_valid, TBL[k][18]);
      if (TBL[k][18]) begin
        chk($sformatf("R3 row%0d kind", k), svc_kind, TBL[k][17:16]);
        chk($sformatf("R7 row%0d vector", k), svc_vector, TBL[k][15:0]);
        svc_ready = 1'b1;
        @(negedge clk);
        svc_ready = 1'b0;
      end else begin
        chk($sformatf("R5 row%0d strobe", k), rd_strobe, 0);
      end
      clr();
      repeat (4) @(negedge clk);
    end

    // R2: held requests, no boundary
    int_en = 1'b1; fix_hi_req = 1'b1; dev_req = 4'b0001;
    repeat (8) @(negedge clk);
    chk("R2 no offer", svc_valid, 0);
    chk("R2 no strobe", rd_strobe, 0);
    clr();
    repeat (4) @(negedge clk);

    // R6 timing: fixed offered next cycle with no strobe
    fix_lo_req = 1'b1;
    repeat (3) @(negedge clk);
    bnd_pulse();
    chk("R6 fixed valid", svc_valid, 1);
    chk("R6 no strobe", rd_strobe, 0);
    chk("R6 vector", svc_vector, 16'o270);
    svc_ready = 1'b1; @(negedge clk); svc_ready = 1'b0;
    clr(); repeat (4) @(negedge clk);

    // R8 chain timing
    dev_req = 4'b0010;
    repeat (3) @(negedge clk);
    bnd_pulse();
    chk("R7 strobe", rd_strobe, 1);
    chk("R7 grant", iak_out, 1);
    chk("R8 not yet", svc_valid, 0);
    @(negedge clk);
    chk("R8 still waiting", svc_valid, 0);
    @(negedge clk);
    chk("R8 valid", svc_valid, 1);
    chk("R8 vector", svc_vector, 16'o304);
    chk("R8 strobe low", rd_strobe, 0);
    svc_ready = 1'b1; @(negedge clk); svc_ready = 1'b0;
    clr(); repeat (4) @(negedge clk);

    // R9 timeout: request withdrawn before slot samples grant
    dev_req = 4'b0100;
    repeat (3) @(negedge clk);
    bnd_pulse();
    dev_req = '0;
    chk("R9 strobe up", rd_strobe, 1);
    repeat (TMO - 1) @(negedge clk);
    chk("R9 strobe before limit", rd_strobe, 1);
    @(negedge clk);
    chk("R9 strobe dropped", rd_strobe, 0);
    chk("R9 timeout pulse", ack_timeout, 1);
    chk("R9 nothing offered", svc_valid, 0);
    @(negedge clk);
    chk("R9 pulse one cycle", ack_timeout, 0);
    repeat (4) @(negedge clk);

    // R10 back-pressure
    fix_hi_req = 1'b1;
    repeat (3) @(negedge clk);
    instr_bnd = 1'b1;
    @(negedge clk);
    halt_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 held valid", svc_valid, 1);
    chk("R10 held kind", svc_kind, 2'd1);
    chk("R10 held vector", svc_vector, 16'o100);
    svc_ready = 1'b1;
    @(negedge clk);
    svc_ready = 1'b0;
    chk("R10 idle after handshake", svc_valid, 0);
    @(negedge clk);
    chk("R10 next valid", svc_valid, 1);
    chk("R3 halt wins", svc_kind, 2'd3);
    instr_bnd = 1'b0;
    svc_ready = 1'b1; @(negedge clk); svc_ready = 1'b0;
    clr(); repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule